// File: doc/BRIEF.md
# UART Channel Mode and Command Front End

This block is the control front end of one channel of a multi-channel serial controller. A processor reaches it through two register addresses. The mode address leads to three 8-bit mode registers, numbered 0 to 1 to 2. A hidden pointer picks which of the three a given access reaches. The command address takes command bytes. Each command byte can turn the receiver and the transmitter on or off. In the same write it can also request one action, such as a reset strobe, a break, a change to the handshake line, a counter/timer mode choice or a pointer reload.

The pointer moves forward after every access to the mode address, and a read moves it just as a write does. It stops at mode register 2. The only way to get back to mode register 0 or 1 is a pointer-reload command. Software that reads the mode address by accident, for example through a spurious bus read, shifts the pointer. Its next write then lands one register further on than it intended.

The outputs are the three stored mode bytes, the two enable flags, four single-cycle reset strobes, a break flag, the handshake (RTS) level and the counter/timer mode flag. The serial shifters, FIFOs and baud logic downstream read these outputs.

Top module: `uart_chan_ctrl`

## Requirements
- R1: Each write to the mode address (acc_valid=1, acc_write=1, acc_is_cmd=0) stores wdata in the mode register the pointer selects, and that byte appears on the matching mr*_q output after the clock edge. The mode registers change on no other access.
- R2: Every access to the mode address advances the pointer by one after the access, whether it is a read (acc_write=0) or a write.
- R3: When the pointer is at mode register 2 it stays there, so further mode accesses keep reaching mode register 2.
- R4: During reset and after it the pointer is at mode register 0. All mode bytes, enable flags, strobes, the break flag, the RTS level and the counter flag are 0.
- R5: A command byte with upper nibble 0xB sets the pointer to mode register 0. Upper nibble 0x1 sets it to mode register 1.
- R6: In a command byte, bit 0 sets rx_en, bit 1 clears rx_en, bit 2 sets tx_en and bit 3 clears tx_en. When a byte has both the set and the clear bit of one direction, that flag ends up 0. The lower nibble acts together with any upper-nibble command in the same byte.
- R7: Upper nibbles 0x2, 0x3, 0x4 and 0x5 pulse rx_rst_pulse, tx_rst_pulse, err_rst_pulse and brk_irq_rst_pulse respectively. Each pulse is high for exactly the one cycle after the command edge.
- R8: Upper nibble 0x6 sets brk_active and 0x7 clears it.
- R9: Upper nibble 0x8 sets rts_active and 0x9 clears it.
- R10: Upper nibble 0xC sets ct_counter_sel (counter mode) and 0xA clears it (timer mode).
- R11: While acc_is_cmd=0, rdata shows the mode register at the pointer. While acc_is_cmd=1, rdata is 0. Accesses to the command address never move the pointer.
- R12: Upper nibbles 0x0, 0xD, 0xE and 0xF change no state beyond what the lower nibble requests. Inputs with acc_valid=0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Register access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_is_cmd | input | 1 | 1 = command address, 0 = mode address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data (mode register at pointer, or 0) |
| mr0_q | output | DATA_W | Mode register 0 |
| mr1_q | output | DATA_W | Mode register 1 |
| mr2_q | output | DATA_W | Mode register 2 |
| rx_en | output | 1 | Receiver enabled |
| tx_en | output | 1 | Transmitter enabled |
| rx_rst_pulse | output | 1 | Receiver reset strobe |
| tx_rst_pulse | output | 1 | Transmitter reset strobe |
| err_rst_pulse | output | 1 | Error status reset strobe |
| brk_irq_rst_pulse | output | 1 | Break-change interrupt reset strobe |
| brk_active | output | 1 | Break being sent |
| rts_active | output | 1 | RTS asserted |
| ct_counter_sel | output | 1 | 1 = counter mode, 0 = timer mode |

## Verification
The bench reads the mode address between writes. A design that moved the pointer on writes only would then put the next byte into the wrong register and show it on the wrong mr*_q output. It keeps accessing past mode register 2 to catch a pointer that wraps to register 0 and so overwrites it. It sends command bytes that set and clear the same direction at once, catching a design that gives the set bit priority. It sends repeated and mixed-nibble commands to catch strobes that last two cycles, or an upper nibble that masks the enable bits. Reads of the command address, idle cycles with the write line high and the unused nibble codes must all leave the pointer and flags exactly where they were.

// File: rtl/ucc_pkg.sv
// Shared definitions for the channel control front end.
// Assumes command bytes are 8 bits wide: low nibble enable bits, high nibble opcode.
package ucc_pkg;

    typedef enum logic [3:0] {
        OP_NONE      = 4'h0,
        OP_PTR_MR1   = 4'h1,
        OP_RST_RX    = 4'h2,
        OP_RST_TX    = 4'h3,
        OP_RST_ERR   = 4'h4,
        OP_RST_BRKIRQ= 4'h5,
        OP_BRK_START = 4'h6,
        OP_BRK_STOP  = 4'h7,
        OP_RTS_SET   = 4'h8,
        OP_RTS_CLR   = 4'h9,
        OP_CT_TIMER  = 4'hA,
        OP_PTR_MR0   = 4'hB,
        OP_CT_COUNT  = 4'hC
    } ucc_op_e;

    // Pointer reload requests
    typedef struct packed {
        logic to_mr0;
        logic to_mr1;
    } ucc_ptr_cmd_t;

    // Channel control requests
    typedef struct packed {
        logic rx_on;
        logic rx_off;
        logic tx_on;
        logic tx_off;
        logic rst_rx;
        logic rst_tx;
        logic rst_err;
        logic rst_brkirq;
        logic brk_start;
        logic brk_stop;
        logic rts_set;
        logic rts_clr;
        logic ct_timer;
        logic ct_count;
    } ucc_ctl_cmd_t;

endpackage

// File: rtl/ucc_mode_file.sv
// Mode register file: NUM_MR registers behind one address, reached by a
// saturating pointer. Assumes at most one access per cycle; a pointer reload
// and a mode access never coincide because they use different addresses.
module ucc_mode_file #(
    parameter int DATA_W = 8,
    parameter int NUM_MR = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_en,
    input  logic                     acc_wr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     ptr_load,
    input  logic [$clog2(NUM_MR)-1:0] ptr_val,
    output logic [NUM_MR*DATA_W-1:0] mr_flat,
    output logic [DATA_W-1:0]        rd_byte
);
    localparam int PTR_W = $clog2(NUM_MR);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_MR - 1);

    logic [PTR_W-1:0]  ptr_q;
    logic [DATA_W-1:0] mr_q [NUM_MR];

    // Pointer: reload on command, otherwise step on each access until the last register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_load) begin
            ptr_q <= ptr_val;
        end else if (acc_en && (ptr_q != PTR_LAST)) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    for (genvar gi = 0; gi < NUM_MR; gi++) begin : g_mr
        // Storage: capture a write aimed at this register
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mr_q[gi] <= '0;
            end else if (acc_en && acc_wr && (ptr_q == PTR_W'(gi))) begin
                mr_q[gi] <= wdata;
            end
        end
        assign mr_flat[gi*DATA_W +: DATA_W] = mr_q[gi];
    end

    // Read path: select the register under the pointer
    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NUM_MR; i++) begin
            if (ptr_q == PTR_W'(i)) rd_byte = mr_q[i];
        end
    end

endmodule

// File: rtl/ucc_cmd_decode.sv
// Command byte decoder: turns one written command byte into flat request bits.
// Purely combinational; outputs are zero unless cmd_wr is high.
module ucc_cmd_decode
    import ucc_pkg::*;
(
    input  logic         cmd_wr,
    input  logic [7:0]   cmd_byte,
    output ucc_ptr_cmd_t ptr_cmd,
    output ucc_ctl_cmd_t ctl_cmd
);
    ucc_op_e op;

    // Opcode extraction from the upper nibble
    always_comb op = ucc_op_e'(cmd_byte[7:4]);

    // Request decode: enable bits plus one opcode action
    always_comb begin
        ptr_cmd = '0;
        ctl_cmd = '0;
        if (cmd_wr) begin
            ctl_cmd.rx_on  = cmd_byte[0];
            ctl_cmd.rx_off = cmd_byte[1];
            ctl_cmd.tx_on  = cmd_byte[2];
            ctl_cmd.tx_off = cmd_byte[3];
            unique case (op)
                OP_PTR_MR1:    ptr_cmd.to_mr1     = 1'b1;
                OP_PTR_MR0:    ptr_cmd.to_mr0     = 1'b1;
                OP_RST_RX:     ctl_cmd.rst_rx     = 1'b1;
                OP_RST_TX:     ctl_cmd.rst_tx     = 1'b1;
                OP_RST_ERR:    ctl_cmd.rst_err    = 1'b1;
                OP_RST_BRKIRQ: ctl_cmd.rst_brkirq = 1'b1;
                OP_BRK_START:  ctl_cmd.brk_start  = 1'b1;
                OP_BRK_STOP:   ctl_cmd.brk_stop   = 1'b1;
                OP_RTS_SET:    ctl_cmd.rts_set    = 1'b1;
                OP_RTS_CLR:    ctl_cmd.rts_clr    = 1'b1;
                OP_CT_TIMER:   ctl_cmd.ct_timer   = 1'b1;
                OP_CT_COUNT:   ctl_cmd.ct_count   = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ucc_ctl_state.sv
// Channel control state: enable flags, break and RTS levels, counter/timer
// select and registered one-cycle reset strobes. Clear requests win over sets.
module ucc_ctl_state
    import ucc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  ucc_ctl_cmd_t req,
    output logic         rx_en,
    output logic         tx_en,
    output logic         rx_rst_pulse,
    output logic         tx_rst_pulse,
    output logic         err_rst_pulse,
    output logic         brk_irq_rst_pulse,
    output logic         brk_active,
    output logic         rts_active,
    output logic         ct_counter_sel
);
    // Enable flags: disable has priority within one byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en <= 1'b0;
            tx_en <= 1'b0;
        end else begin
            if (req.rx_off)     rx_en <= 1'b0;
            else if (req.rx_on) rx_en <= 1'b1;
            if (req.tx_off)     tx_en <= 1'b0;
            else if (req.tx_on) tx_en <= 1'b1;
        end
    end

    // Level state: break, RTS and counter/timer select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_active     <= 1'b0;
            rts_active     <= 1'b0;
            ct_counter_sel <= 1'b0;
        end else begin
            if (req.brk_start)     brk_active <= 1'b1;
            else if (req.brk_stop) brk_active <= 1'b0;
            if (req.rts_set)       rts_active <= 1'b1;
            else if (req.rts_clr)  rts_active <= 1'b0;
            if (req.ct_count)      ct_counter_sel <= 1'b1;
            else if (req.ct_timer) ct_counter_sel <= 1'b0;
        end
    end

    // Strobes: one registered cycle per reset request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_rst_pulse      <= 1'b0;
            tx_rst_pulse      <= 1'b0;
            err_rst_pulse     <= 1'b0;
            brk_irq_rst_pulse <= 1'b0;
        end else begin
            rx_rst_pulse      <= req.rst_rx;
            tx_rst_pulse      <= req.rst_tx;
            err_rst_pulse     <= req.rst_err;
            brk_irq_rst_pulse <= req.rst_brkirq;
        end
    end

endmodule

// File: rtl/uart_chan_ctrl.sv
// Per-channel control front end: mode register file behind a moving pointer
// and a command register decoder. Assumes DATA_W >= 8; commands use wdata[7:0].
module uart_chan_ctrl
    import ucc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_is_cmd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] mr0_q,
    output logic [DATA_W-1:0] mr1_q,
    output logic [DATA_W-1:0] mr2_q,
    output logic              rx_en,
    output logic              tx_en,
    output logic              rx_rst_pulse,
    output logic              tx_rst_pulse,
    output logic              err_rst_pulse,
    output logic              brk_irq_rst_pulse,
    output logic              brk_active,
    output logic              rts_active,
    output logic              ct_counter_sel
);
    localparam int NUM_MR = 3;
    localparam int PTR_W  = $clog2(NUM_MR);

    logic                     mode_acc;
    logic                     cmd_wr;
    ucc_ptr_cmd_t             ptr_cmd;
    ucc_ctl_cmd_t             ctl_cmd;
    logic                     ptr_load;
    logic [PTR_W-1:0]         ptr_val;
    logic [NUM_MR*DATA_W-1:0] mr_flat;
    logic [DATA_W-1:0]        rd_byte;

    // Address qualification
    always_comb begin
        mode_acc = acc_valid && !acc_is_cmd;
        cmd_wr   = acc_valid && acc_write && acc_is_cmd;
    end

    ucc_cmd_decode i_dec (
        .cmd_wr   (cmd_wr),
        .cmd_byte (wdata[7:0]),
        .ptr_cmd  (ptr_cmd),
        .ctl_cmd  (ctl_cmd)
    );

    // Pointer reload target from the decoded command
    always_comb begin
        ptr_load = ptr_cmd.to_mr0 || ptr_cmd.to_mr1;
        ptr_val  = ptr_cmd.to_mr1 ? PTR_W'(1) : PTR_W'(0);
    end

    ucc_mode_file #(.DATA_W(DATA_W), .NUM_MR(NUM_MR)) i_mf (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en   (mode_acc),
        .acc_wr   (acc_write),
        .wdata    (wdata),
        .ptr_load (ptr_load),
        .ptr_val  (ptr_val),
        .mr_flat  (mr_flat),
        .rd_byte  (rd_byte)
    );

    ucc_ctl_state i_st (
        .clk               (clk),
        .rst_n             (rst_n),
        .req               (ctl_cmd),
        .rx_en             (rx_en),
        .tx_en             (tx_en),
        .rx_rst_pulse      (rx_rst_pulse),
        .tx_rst_pulse      (tx_rst_pulse),
        .err_rst_pulse     (err_rst_pulse),
        .brk_irq_rst_pulse (brk_irq_rst_pulse),
        .brk_active        (brk_active),
        .rts_active        (rts_active),
        .ct_counter_sel    (ct_counter_sel)
    );

    // Output mapping: mode bytes and read mux
    always_comb begin
        mr0_q = mr_flat[0*DATA_W +: DATA_W];
        mr1_q = mr_flat[1*DATA_W +: DATA_W];
        mr2_q = mr_flat[2*DATA_W +: DATA_W];
        rdata = acc_is_cmd ? '0 : rd_byte;
    end

endmodule

// File: rtl/ucc_checker.sv
// Protocol checker for uart_chan_ctrl, attached by bind. Observes ports only.
module ucc_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic              acc_is_cmd,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] mr0_q,
    input logic [DATA_W-1:0] mr1_q,
    input logic [DATA_W-1:0] mr2_q,
    input logic              rx_en,
    input logic              rx_rst_pulse,
    input logic              tx_rst_pulse,
    input logic              err_rst_pulse,
    input logic              brk_irq_rst_pulse,
    input logic              brk_active,
    input logic              rts_active
);
    logic cw;
    logic mw;

    // Access classification for the properties
    always_comb begin
        cw = acc_valid && acc_write && acc_is_cmd;
        mw = acc_valid && acc_write && !acc_is_cmd;
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mw |=> $stable({mr0_q, mr1_q, mr2_q})); // R1
    AST_RX_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && wdata[1]) |=> !rx_en); // R6
    AST_RX_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && wdata[0] && !wdata[1]) |=> rx_en); // R6
    AST_RX_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst_pulse |-> $past(cw && (wdata[7:4] == 4'h2))); // R7
    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_rst_pulse, tx_rst_pulse, err_rst_pulse, brk_irq_rst_pulse})); // R7
    AST_BREAK_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && (wdata[7:4] == 4'h6)) |=> brk_active); // R8
    AST_RTS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && (wdata[7:4] == 4'h9)) |=> !rts_active); // R9

endmodule

bind uart_chan_ctrl ucc_checker #(.DATA_W(DATA_W)) i_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .acc_valid         (acc_valid),
    .acc_write         (acc_write),
    .acc_is_cmd        (acc_is_cmd),
    .wdata             (wdata),
    .mr0_q             (mr0_q),
    .mr1_q             (mr1_q),
    .mr2_q             (mr2_q),
    .rx_en             (rx_en),
    .rx_rst_pulse      (rx_rst_pulse),
    .tx_rst_pulse      (tx_rst_pulse),
    .err_rst_pulse     (err_rst_pulse),
    .brk_irq_rst_pulse (brk_irq_rst_pulse),
    .brk_active        (brk_active),
    .rts_active        (rts_active)
);

// File: tb/test_uart_chan_ctrl.sv
// Bench for uart_chan_ctrl: behavioural reference model compared every clock.
module test_uart_chan_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic       acc_write = 1'b0;
    logic       acc_is_cmd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata, mr0_q, mr1_q, mr2_q;
    logic rx_en, tx_en, rx_rst_pulse, tx_rst_pulse, err_rst_pulse, brk_irq_rst_pulse;
    logic brk_active, rts_active, ct_counter_sel;

    int errors = 0;
    int checks = 0;

    // Reference model state
    int m_ptr;
    int m_mr [3];
    int m_rx, m_tx, m_srx, m_stx, m_serr, m_sbrk, m_brk, m_rts, m_ct;

    always #10 clk = ~clk;

    uart_chan_ctrl #(.DATA_W(8)) i_uart_chan_ctrl (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_is_cmd(acc_is_cmd), .wdata(wdata), .rdata(rdata),
        .mr0_q(mr0_q), .mr1_q(mr1_q), .mr2_q(mr2_q), .rx_en(rx_en), .tx_en(tx_en),
        .rx_rst_pulse(rx_rst_pulse), .tx_rst_pulse(tx_rst_pulse),
        .err_rst_pulse(err_rst_pulse), .brk_irq_rst_pulse(brk_irq_rst_pulse),
        .brk_active(brk_active), .rts_active(rts_active), .ct_counter_sel(ct_counter_sel)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ptr = 0;
        for (int i = 0; i < 3; i++) m_mr[i] = 0;
        m_rx = 0; m_tx = 0; m_srx = 0; m_stx = 0; m_serr = 0; m_sbrk = 0;
        m_brk = 0; m_rts = 0; m_ct = 0;
    endtask

    task automatic compare_regs(input string tag);
        check({tag, " R1 mr0"}, mr0_q, m_mr[0]);
        check({tag, " R1 mr1"}, mr1_q, m_mr[1]);
        check({tag, " R1 mr2"}, mr2_q, m_mr[2]);
        check({tag, " R6 rx_en"}, rx_en, m_rx);
        check({tag, " R6 tx_en"}, tx_en, m_tx);
        check({tag, " R7 rx_rst"}, rx_rst_pulse, m_srx);
        check({tag, " R7 tx_rst"}, tx_rst_pulse, m_stx);
        check({tag, " R7 err_rst"}, err_rst_pulse, m_serr);
        check({tag, " R7 brk_irq_rst"}, brk_irq_rst_pulse, m_sbrk);
        check({tag, " R8 brk"}, brk_active, m_brk);
        check({tag, " R9 rts"}, rts_active, m_rts);
        check({tag, " R10 ct"}, ct_counter_sel, m_ct);
    endtask

    // One bus cycle: drive at negedge, check read path, then update model at edge
    task automatic step(input logic v, input logic w, input logic c, input logic [7:0] d,
                        input string tag);
        int op;
        acc_valid = v; acc_write = w; acc_is_cmd = c; wdata = d;
        #2;
        check({tag, " R11 rdata"}, rdata, c ? 0 : m_mr[m_ptr]);
        @(posedge clk);
        m_srx = 0; m_stx = 0; m_serr = 0; m_sbrk = 0;
        if (v && !c) begin
            if (w) m_mr[m_ptr] = d;
            if (m_ptr < 2) m_ptr++;
        end else if (v && w && c) begin
            op = d[7:4];
            if (d[0]) m_rx = 1;
            if (d[1]) m_rx = 0;
            if (d[2]) m_tx = 1;
            if (d[3]) m_tx = 0;
            case (op)
                1:  m_ptr = 1;
                2:  m_srx = 1;
                3:  m_stx = 1;
                4:  m_serr = 1;
                5:  m_sbrk = 1;
                6:  m_brk = 1;
                7:  m_brk = 0;
                8:  m_rts = 1;
                9:  m_rts = 0;
                10: m_ct = 0;
                11: m_ptr = 0;
                12: m_ct = 1;
                default: ;
            endcase
        end
        #2;
        compare_regs(tag);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        compare_regs("R4 reset");
        check("R4 rdata", rdata, 0);

        // R1: sequential writes fill MR0, MR1, MR2
        step(1, 1, 0, 8'hA1, "R1");
        step(1, 1, 0, 8'hB2, "R1");
        step(1, 1, 0, 8'hC3, "R1");
        // R3: pointer stuck at MR2
        step(1, 1, 0, 8'hD4, "R3");
        step(1, 1, 0, 8'hE5, "R3");
        step(1, 0, 0, 8'h00, "R3");
        // R5 then R2: reads move the pointer too
        step(1, 1, 1, 8'hB0, "R5");
        step(1, 0, 0, 8'h00, "R2");
        step(1, 0, 0, 8'h00, "R2");
        step(1, 1, 0, 8'h77, "R2");
        // R5: point at MR1, write an 8N1 style value then MR2
        step(1, 1, 1, 8'h10, "R5");
        step(1, 1, 0, 8'h13, "R5");
        step(1, 1, 0, 8'h17, "R5");
        // R11: command-address reads give 0 and do not move the pointer
        step(1, 1, 1, 8'hB0, "R11");
        step(1, 0, 1, 8'h00, "R11");
        step(1, 0, 1, 8'h00, "R11");
        step(0, 0, 0, 8'h00, "R11");
        step(1, 1, 0, 8'h5A, "R11");
        // R6: enable and disable, clear wins
        step(1, 1, 1, 8'h05, "R6");
        step(1, 1, 1, 8'h03, "R6");
        step(1, 1, 1, 8'h0C, "R6");
        step(1, 1, 1, 8'h05, "R6");
        step(1, 1, 1, 8'h0A, "R6");
        // R7: strobes, including back to back
        step(1, 1, 1, 8'h20, "R7");
        step(1, 1, 1, 8'h30, "R7");
        step(1, 1, 1, 8'h40, "R7");
        step(1, 1, 1, 8'h50, "R7");
        step(1, 1, 1, 8'h20, "R7");
        step(1, 1, 1, 8'h20, "R7");
        step(0, 0, 0, 8'h00, "R7");
        // R8 and R9
        step(1, 1, 1, 8'h60, "R8");
        step(1, 1, 1, 8'h70, "R8");
        step(1, 1, 1, 8'h60, "R8");
        step(1, 1, 1, 8'h80, "R9");
        step(1, 1, 1, 8'h90, "R9");
        step(1, 1, 1, 8'h85, "R9");
        // R10: counter then timer
        step(1, 1, 1, 8'hC0, "R10");
        step(1, 1, 1, 8'hA0, "R10");
        step(1, 1, 1, 8'hC0, "R10");
        // R12: unused opcodes and idle inputs change nothing
        step(1, 1, 1, 8'hD0, "R12");
        step(1, 1, 1, 8'hE0, "R12");
        step(1, 1, 1, 8'hF0, "R12");
        step(1, 1, 1, 8'h00, "R12");
        step(0, 1, 1, 8'h2A, "R12");
        step(0, 1, 0, 8'hFF, "R12");
        step(1, 1, 1, 8'hF2, "R12");
        step(1, 0, 0, 8'h00, "R12");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule